// File: doc/BRIEF.md
# Multicast GPIO Interrupt Pending State

This block holds the pending state of sixteen edge-triggered GPIO interrupt sources that several processor cores share. Every pin keeps a common pending bit. A small window of pins, 4 to 7 by default, also keeps one pending copy per core. When a global multicast switch is on, each core sees and acknowledges its own copy of those pins without disturbing the other cores. Outside that window, and whenever the switch is off, every core sees the common bit.

Each pin's behaviour depends on its own enable and type inputs and on the multicast switch. An edge event on a pin that is enabled as an edge interrupt sets the common bit and every per-core copy. Three kinds of acknowledge exist: a per-core write-one-to-clear that carries a core index, a common write-one-to-clear, and a global clear mask that wipes every copy. Which of them acts on a given pin depends on the pin's current mode. The state is read through a common vector and through a flattened per-core view vector. Summary masking and routing to the cores are handled outside this block.

Top module: `mcast_irq_state`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `com_pend` and every bit of `core_pend` are 0.
- R2: An `edge_evt` bit on a pin whose `int_en` and `int_edge` bits are both 1 sets the pin's common bit and all of its per-core copies after the next clock edge. Events on other pins set nothing.
- R3: With `mc_en`=1 and a window pin (4 to 7) enabled as an edge interrupt, a per-core write with mask bit p set clears only the copy of core `core_wr_idx`. The other cores' copies and the common bit keep their values.
- R4: In the same mode, a common write with mask bit p set clears only the common bit. Every per-core copy keeps its value.
- R5: A 1 in `gclr_mask` bit p clears the common bit and every copy of pin p after the next edge, in every mode.
- R6: With `mc_en`=0, per-core and common writes change no pin's state.
- R7: With `mc_en`=1, for a pin outside the window that is enabled as an edge interrupt, a per-core write or a common write with mask bit p set clears the common bit.
- R8: For a pin whose `int_en` or `int_edge` bit is 0, per-core and common writes have no effect on its state. Only the global clear acts on it.
- R9: If an event that R2 would latch coincides with any clear of the same pin, the pin is set after the edge.
- R10: Bit c*16+p of `core_pend` shows core c's own copy when p is a window pin, `mc_en`=1 and the pin is enabled as an edge interrupt. In every other case it shows `com_pend[p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_en | input | 1 | Multicast switch for the window pins |
| int_en | input | 16 | Per-pin interrupt enable |
| int_edge | input | 16 | Per-pin type: 1 = edge, 0 = level |
| edge_evt | input | 16 | Per-pin edge event pulse |
| core_wr_vld | input | 1 | Per-core write-one-to-clear strobe |
| core_wr_idx | input | 3 | Core issuing the per-core write |
| core_wr_mask | input | 16 | Per-core clear mask, one bit per pin |
| com_wr_vld | input | 1 | Common write-one-to-clear strobe |
| com_wr_mask | input | 16 | Common clear mask |
| gclr_mask | input | 16 | Global clear, one bit per pin |
| com_pend | output | 16 | Common pending state |
| core_pend | output | 128 | Per-core view, bit c*16+p |

## Verification
A new edge event can land in the same cycle as a clear of the same pin, and the clear can come from any of the three paths: per-core, common or global. The bench provokes this on purpose by pulsing events together with all three clears on two window pins while multicast is on. It also produces such collisions at random in a long mixed phase. The pin must come out set, both in common and in every core's copy. The behavioural reference model judges this on every clock, and a bound property on the common vector checks it as well.

// File: rtl/mcast_irq_pkg.sv
package mcast_irq_pkg;

   // Per-pin operating mode, derived from enable, type and the multicast switch
   typedef enum logic [1:0] {
      PM_IDLE         = 2'd0,  // not an enabled edge source: writes ignored
      PM_EDGE_RO      = 2'd1,  // edge source, multicast off: summary read-only
      PM_EDGE_SHARED  = 2'd2,  // edge source outside window, multicast on
      PM_EDGE_PERCORE = 2'd3   // window pin, multicast on: per-core copies live
   } pin_mode_e;

   function automatic bit in_mc_window(input int pin, input int lo, input int hi);
      return (pin >= lo) && (pin <= hi);
   endfunction

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mcast_irq_mode.sv
module mcast_irq_mode
   import mcast_irq_pkg::*;
#(
   parameter bit HAS_COPIES = 1'b0
) (
   input  logic      irq_en,
   input  logic      irq_edge,
   input  logic      mc_on,
   output pin_mode_e mode
);

   always_comb begin
      if (!(irq_en && irq_edge)) begin
         mode = PM_IDLE;
      end else if (!mc_on) begin
         mode = PM_EDGE_RO;
      end else if (HAS_COPIES) begin
         mode = PM_EDGE_PERCORE;
      end else begin
         mode = PM_EDGE_SHARED;
      end
   end

endmodule

// File: rtl/mcast_irq_common_bit.sv
module mcast_irq_common_bit
   import mcast_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_e mode,
   input  logic      evt,
   input  logic      gclr,
   input  logic      core_hit,
   input  logic      com_hit,
   output logic      pend
);

   logic set_now;
   logic clr_now;

   assign set_now = evt && (mode != PM_IDLE);

   always_comb begin
      unique case (mode)
         PM_EDGE_SHARED:  clr_now = gclr || core_hit || com_hit;
         PM_EDGE_PERCORE: clr_now = gclr || com_hit;
         default:         clr_now = gclr;
      endcase
   end

   // a fresh event outranks every clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (set_now) begin
         pend <= 1'b1;
      end else if (clr_now) begin
         pend <= 1'b0;
      end
   end

endmodule

// File: rtl/mcast_irq_core_bank.sv
module mcast_irq_core_bank
   import mcast_irq_pkg::*;
#(
   parameter int NUM_CORES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pin_mode_e            mode,
   input  logic                 evt,
   input  logic                 gclr,
   input  logic [NUM_CORES-1:0] core_sel,
   output logic [NUM_CORES-1:0] copies
);

   logic set_now;
   logic own_ok;

   assign set_now = evt && (mode != PM_IDLE);
   assign own_ok  = (mode == PM_EDGE_PERCORE);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_copy
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            copies[c] <= 1'b0;
         end else if (set_now) begin
            copies[c] <= 1'b1;
         end else if (gclr || (own_ok && core_sel[c])) begin
            copies[c] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mcast_irq_state.sv
module mcast_irq_state
   import mcast_irq_pkg::*;
#(
   parameter int NUM_PINS  = 16,
   parameter int NUM_CORES = 8,
   parameter int MC_LO     = 4,
   parameter int MC_HI     = 7,
   localparam int CORE_W   = idx_width(NUM_CORES),
   localparam int VIEW_W   = NUM_CORES * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mc_en,
   input  logic [NUM_PINS-1:0] int_en,
   input  logic [NUM_PINS-1:0] int_edge,
   input  logic [NUM_PINS-1:0] edge_evt,
   input  logic                core_wr_vld,
   input  logic [CORE_W-1:0]   core_wr_idx,
   input  logic [NUM_PINS-1:0] core_wr_mask,
   input  logic                com_wr_vld,
   input  logic [NUM_PINS-1:0] com_wr_mask,
   input  logic [NUM_PINS-1:0] gclr_mask,
   output logic [NUM_PINS-1:0] com_pend,
   output logic [VIEW_W-1:0]   core_pend
);

   // elaboration-time parameter checks
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("mcast_irq_state: NUM_PINS must be at least 1");
   end
   if (NUM_CORES < 1) begin : g_bad_cores
      $error("mcast_irq_state: NUM_CORES must be at least 1");
   end
   if ((MC_LO < 0) || (MC_HI < MC_LO) || (MC_HI >= NUM_PINS)) begin : g_bad_window
      $error("mcast_irq_state: multicast window out of range");
   end

   // one-hot decode of the writing core; out-of-range indices select nobody
   logic [NUM_CORES-1:0] wr_onehot;
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
      assign wr_onehot[c] = core_wr_vld && (core_wr_idx == CORE_W'(c));
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam bit IS_MC = in_mc_window(p, MC_LO, MC_HI);

      pin_mode_e            mode;
      logic [NUM_CORES-1:0] sel;
      logic                 core_hit;
      logic                 com_hit;

      assign sel      = wr_onehot & {NUM_CORES{core_wr_mask[p]}};
      assign core_hit = |sel;
      assign com_hit  = com_wr_vld && com_wr_mask[p];

      mcast_irq_mode #(.HAS_COPIES(IS_MC)) mode_i (
         .irq_en   (int_en[p]),
         .irq_edge (int_edge[p]),
         .mc_on    (mc_en),
         .mode     (mode)
      );

      mcast_irq_common_bit com_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode     (mode),
         .evt      (edge_evt[p]),
         .gclr     (gclr_mask[p]),
         .core_hit (core_hit),
         .com_hit  (com_hit),
         .pend     (com_pend[p])
      );

      if (IS_MC) begin : g_copies
         logic [NUM_CORES-1:0] copies;

         mcast_irq_core_bank #(.NUM_CORES(NUM_CORES)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .evt      (edge_evt[p]),
            .gclr     (gclr_mask[p]),
            .core_sel (sel),
            .copies   (copies)
         );

         for (genvar c = 0; c < NUM_CORES; c++) begin : g_view
            assign core_pend[c*NUM_PINS + p] =
               (mode == PM_EDGE_PERCORE) ? copies[c] : com_pend[p];
         end
      end else begin : g_shared
         for (genvar c = 0; c < NUM_CORES; c++) begin : g_view
            assign core_pend[c*NUM_PINS + p] = com_pend[p];
         end
      end
   end

endmodule

// File: rtl/mcast_irq_state_chk.sv
module mcast_irq_state_chk #(
   parameter int NUM_PINS  = 16,
   parameter int NUM_CORES = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          mc_en,
   input logic [NUM_PINS-1:0]           int_en,
   input logic [NUM_PINS-1:0]           int_edge,
   input logic [NUM_PINS-1:0]           edge_evt,
   input logic [NUM_PINS-1:0]           gclr_mask,
   input logic [NUM_PINS-1:0]           com_pend,
   input logic [NUM_CORES*NUM_PINS-1:0] core_pend
);

   logic [NUM_PINS-1:0] live;
   assign live = edge_evt & int_en & int_edge;

   // R1: reset leaves every pending bit clear
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> ((com_pend == '0) && (core_pend == '0)));

   // R2: a common bit only rises after a latched event
   a_r2_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      ((com_pend & ~$past(com_pend) & ~$past(live)) == '0));

   // R5: global clear wipes pins not hit by an event
   a_r5_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (gclr_mask != '0) |=> ((com_pend & $past(gclr_mask & ~live)) == '0));

   // R6: with multicast off only the global clear lowers a common bit
   a_r6_readonly_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mc_en |=> ((~com_pend & $past(com_pend) & ~$past(gclr_mask)) == '0));

   // R9: a latched event always wins
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (live != '0) |=> ((com_pend & $past(live)) == $past(live)));

endmodule

bind mcast_irq_state mcast_irq_state_chk #(
   .NUM_PINS  (NUM_PINS),
   .NUM_CORES (NUM_CORES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .mc_en     (mc_en),
   .int_en    (int_en),
   .int_edge  (int_edge),
   .edge_evt  (edge_evt),
   .gclr_mask (gclr_mask),
   .com_pend  (com_pend),
   .core_pend (core_pend)
);

// File: tb/mcast_irq_state_tb.sv
module mcast_irq_state_tb_top;

   localparam int NP = 16;
   localparam int NC = 8;
   localparam int CW = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            mc_en;
   logic [NP-1:0]   int_en, int_edge, edge_evt;
   logic            core_wr_vld;
   logic [CW-1:0]   core_wr_idx;
   logic [NP-1:0]   core_wr_mask;
   logic            com_wr_vld;
   logic [NP-1:0]   com_wr_mask, gclr_mask;
   logic [NP-1:0]   com_pend;
   logic [NC*NP-1:0] core_pend;

   int    nchk = 0;
   int    nbad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #4 clk = ~clk;   // 125 MHz

   mcast_irq_state dut_i (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .int_en(int_en),
      .int_edge(int_edge), .edge_evt(edge_evt), .core_wr_vld(core_wr_vld),
      .core_wr_idx(core_wr_idx), .core_wr_mask(core_wr_mask),
      .com_wr_vld(com_wr_vld), .com_wr_mask(com_wr_mask),
      .gclr_mask(gclr_mask), .com_pend(com_pend), .core_pend(core_pend)
   );

   // ---------------- reference model ----------------
   bit m_com [NP];
   bit m_cp  [NC][NP];

   function automatic bit win(input int p);
      return (p >= 4) && (p <= 7);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            m_com[p] = 0;
            for (int c = 0; c < NC; c++) m_cp[c][p] = 0;
         end
      end else begin
         for (int p = 0; p < NP; p++) begin
            bit armed;
            bit cw, pw;
            armed = int_en[p] && int_edge[p];
            cw = core_wr_vld && core_wr_mask[p];
            pw = com_wr_vld && com_wr_mask[p];
            if (armed && edge_evt[p]) begin
               m_com[p] = 1;
               for (int c = 0; c < NC; c++) m_cp[c][p] = 1;
            end else if (gclr_mask[p]) begin
               m_com[p] = 0;
               for (int c = 0; c < NC; c++) m_cp[c][p] = 0;
            end else if (armed && mc_en) begin
               if (win(p)) begin
                  if (cw) m_cp[core_wr_idx][p] = 0;
                  if (pw) m_com[p] = 0;
               end else if (cw || pw) begin
                  m_com[p] = 0;
               end
            end
         end
      end
   end

   function automatic logic [NP-1:0] exp_com();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = m_com[p];
      return v;
   endfunction

   function automatic logic [NC*NP-1:0] exp_view();
      logic [NC*NP-1:0] v;
      for (int c = 0; c < NC; c++)
         for (int p = 0; p < NP; p++)
            v[c*NP+p] = (win(p) && mc_en && int_en[p] && int_edge[p])
                        ? m_cp[c][p] : m_com[p];
      return v;
   endfunction

   // per-clock comparison against the model, away from the edges
   always @(negedge clk) begin
      #2;
      if (rst_n === 1'b1 && !done) begin
         nchk++;
         if (com_pend !== exp_com() || core_pend !== exp_view()) begin
            nbad++;
            $display("FAIL %s model: com=%h/%h view=%h expected com=%h view=%h",
                     cur_req, com_pend, exp_com(), core_pend, exp_com(), exp_view());
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [NC*NP-1:0] act,
                      input logic [NC*NP-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [NP-1:0] evt, input logic [NP-1:0] gclr,
                        input logic cv, input logic [CW-1:0] ci,
                        input logic [NP-1:0] cm, input logic pv,
                        input logic [NP-1:0] pm);
      @(negedge clk);
      edge_evt = evt; gclr_mask = gclr;
      core_wr_vld = cv; core_wr_idx = ci; core_wr_mask = cm;
      com_wr_vld = pv; com_wr_mask = pm;
      @(negedge clk);
      edge_evt = '0; gclr_mask = '0;
      core_wr_vld = 0; core_wr_idx = '0; core_wr_mask = '0;
      com_wr_vld = 0; com_wr_mask = '0;
      #3;
   endtask

   function automatic int bi(input int c, input int p);
      return c*NP + p;
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         nbad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      rst_n = 0; mc_en = 0; int_en = '0; int_edge = '0; edge_evt = '0;
      core_wr_vld = 0; core_wr_idx = '0; core_wr_mask = '0;
      com_wr_vld = 0; com_wr_mask = '0; gclr_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #3;
      cur_req = "R1";
      chk("R1", {112'd0, com_pend}, '0);
      chk("R1", core_pend, '0);

      // R2: events latch only on enabled edge pins (pin 2 disabled)
      cur_req = "R2";
      @(negedge clk);
      int_en = 16'hFFFB; int_edge = 16'hFFFF;
      pulse(16'h01F4, '0, 0, '0, '0, 0, '0);
      chk("R2", {112'd0, com_pend}, {112'd0, 16'h01F0});
      chk("R2", core_pend, {NC{16'h01F0}});

      // R3 / R10: core 3 acknowledges its own copy of pin 4
      cur_req = "R3";
      @(negedge clk); mc_en = 1;
      pulse('0, '0, 1, 3'd3, 16'h0010, 0, '0);
      chk("R3", {127'd0, core_pend[bi(3,4)]}, '0);
      chk("R3", {127'd0, core_pend[bi(2,4)]}, 1);
      chk("R3", {127'd0, com_pend[4]}, 1);

      // R4: common write clears only the common bit of pin 5
      cur_req = "R4";
      pulse('0, '0, 0, '0, '0, 1, 16'h0020);
      chk("R4", {127'd0, com_pend[5]}, '0);
      for (int c = 0; c < NC; c++)
         chk("R10", {127'd0, core_pend[bi(c,5)]}, 1);

      // R7: per-core write on a shared pin clears the common bit
      cur_req = "R7";
      pulse('0, '0, 1, 3'd1, 16'h0100, 0, '0);
      chk("R7", {127'd0, com_pend[8]}, '0);
      chk("R7", {127'd0, core_pend[bi(5,8)]}, '0);

      // R6: multicast off, writes are ignored
      cur_req = "R6";
      @(negedge clk); mc_en = 0;
      pulse('0, '0, 1, 3'd0, 16'hFFFF, 1, 16'hFFFF);
      chk("R6", {112'd0, com_pend}, {112'd0, 16'h00D0});
      chk("R6", {127'd0, core_pend[bi(3,4)]}, 1);

      // R8: level pin 6 and disabled pin 7 ignore writes
      cur_req = "R8";
      @(negedge clk); mc_en = 1; int_edge = 16'hFFBF; int_en = 16'hFF7B;
      pulse('0, '0, 1, 3'd0, 16'hFFFF, 1, 16'hFFFF);
      chk("R8", {112'd0, com_pend}, {112'd0, 16'h00C0});
      chk("R8", {127'd0, core_pend[bi(2,6)]}, 1);

      // R5: global clear wipes everything
      cur_req = "R5";
      pulse('0, 16'hFFFF, 0, '0, '0, 0, '0);
      chk("R5", {112'd0, com_pend}, '0);
      @(negedge clk); int_en = 16'hFFFF; int_edge = 16'hFFFF;
      #3;
      chk("R5", core_pend, '0);

      // R9: events coincide with every kind of clear
      cur_req = "R9";
      pulse(16'h0030, 16'h0030, 1, 3'd2, 16'h0030, 1, 16'h0030);
      chk("R9", {112'd0, com_pend}, {112'd0, 16'h0030});
      chk("R9", {127'd0, core_pend[bi(2,4)]}, 1);
      chk("R9", {127'd0, core_pend[bi(2,5)]}, 1);

      // mixed random traffic judged by the model (R10 and all others)
      cur_req = "R10";
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (($urandom % 16) == 0) begin
            mc_en    = $urandom;
            int_en   = $urandom | $urandom;
            int_edge = $urandom | $urandom;
         end
         edge_evt     = $urandom & $urandom & $urandom;
         gclr_mask    = (($urandom % 8) == 0) ? NP'($urandom) : '0;
         core_wr_vld  = $urandom;
         core_wr_idx  = $urandom;
         core_wr_mask = $urandom;
         com_wr_vld   = (($urandom % 3) == 0);
         com_wr_mask  = $urandom;
      end
      @(negedge clk);
      edge_evt = '0; gclr_mask = '0; core_wr_vld = 0; com_wr_vld = 0;
      repeat (2) @(negedge clk);
      #4;
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule